// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs one access to a serial flash for each command word that software writes. Software first loads an address register and a data register, then writes a command word. The engine drives one active-low chip select and shifts the access out over a single-bit, half-duplex SPI bus in mode 3. Each access has up to four parts, always in this order: an opcode byte, zero to three address bytes, zero to fifteen dummy bytes, and zero to four data bytes. The data bytes are either written from the data register or read into it.

A status register shows a pending flag while an access is in flight, and a sticky error flag. A keep-selected bit in the command word leaves chip select asserted after the access. The next command then continues the same flash transaction without sending an opcode. In this way a long read or program sequence is built from small commands of at most four data bytes each.

The serial clock runs at the system clock divided by 2 × `HALF_DIV`. Register access uses a 2-bit select with a write strobe. Read data is combinational.

Top module: `flash_seq`

## Requirements
- R1: After reset, every `csN` line is high, `sclk` is high, `mosi` is low and the status register reads zero.
- R2: The register select codes are 0 command, 1 address, 2 data and 3 status. The command word fields are:
  - opcode in bits 7:0
  - write direction in bit 8
  - data length in bits 11:9
  - keep-selected in bit 15
  - dummy length in bits 19:16
  - address length in bits 22:20
  - chip-select index in bits 26:24

  An accepted command from the deselected state pulls `csN[index]` low and sends the opcode first. Every byte goes out most significant bit first.
- R3: After the opcode come the address bytes. These are the low 24 bits of the address register, most significant byte first. An address length above 3 is treated as 3, and a length of 2 sends bits 15:0.
- R4: After the address come the dummy bytes, 0 to 15 of them, each driven as 0x00.
- R5: In a write command the data bytes come from the data register, bits 7:0 first and then successively higher bytes. A data length above 4 is treated as 4.
- R6: In a read command `mosi` stays low for the data phase. Each received byte is stored little-endian into the data register, the first byte in bits 7:0. Byte lanes beyond the data length keep their contents, and `miso` is ignored outside the data phase.
- R7: The bus follows SPI mode 3. `sclk` idles high, `mosi` changes on falling edges, `miso` is sampled on rising edges, and at most one `csN` line is low at a time.
- R8: Status bit 22 (pending) reads 1 from the cycle after the command write until the access completes. When keep-selected is 0, chip select is released at completion.
- R9: With keep-selected set, chip select stays low after the command. The next command reuses the held line, ignores its own index and sends no opcode. A command with no address, dummy or data bytes and keep-selected clear, issued while the line is held, releases chip select without clocking.
- R10: A command written while pending is set is discarded and sets status bit 29. Writing 1 to status bit 29 clears it.
- R11: Writes to the address or data register while pending is set are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 2 | Register select: 0 command, 1 address, 2 data, 3 status |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Contents of the selected register |
| sclk | output | 1 | Serial clock, idles high |
| csN | output | CS_COUNT | Active-low chip selects |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
The hardest situation to reach is a transaction that spans several commands under a held chip select. In that case the byte stream must skip the opcode, and the second command's chip-select index must have no effect. The bench chains three commands: one with an opcode and address and keep-selected set, then a four-byte read with keep-selected set and a different index, then an empty release command. Throughout the chain a flash model counts chip-select releases and checks the byte order on the wire.

The other hard case is a command arriving while one is in flight. The bench overlaps register writes with a running access and checks both the error flag and the bytes that actually reach the wire.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
package flash_seq_pkg;
  localparam logic [1:0] SEL_CMD  = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;
  localparam int BIT_PEND = 22;
  localparam int BIT_ERR  = 29;

  typedef enum logic [1:0] {K_OPC, K_ADDR, K_DUMMY, K_DATA} byteKind_t;

  typedef struct packed {
    logic [2:0] csIdx;
    logic       keep;
    logic       isWrite;
    logic [1:0] addrLen;
    logic [3:0] dummyLen;
    logic [2:0] dataLen;
  } cmdFields_t;

  typedef struct packed {
    logic      load;
    logic      fall;
    logic      rise;
    logic      store;
    byteKind_t kind;
    logic [1:0] lane;
  } seqStrobe_t;
endpackage

// File: rtl/flash_seq_ctrl.sv
`timescale 1ns/1ps
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int CS_COUNT = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  cmdFields_t          cmd,
  output logic                busy,
  output seqStrobe_t          stb,
  output logic                sclk,
  output logic [CS_COUNT-1:0] csN
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT, S_END} state_t;

  state_t           state;
  logic [DIV_W-1:0] divCnt;
  logic [2:0]       bitCnt;
  logic [4:0]       byteIdx;
  logic             sckReg, csActive, held;
  logic [2:0]       csSel;
  logic [4:0]       opcEnd, addrEnd, dumEnd, total;
  logic             tick, lastBit;

  always_comb begin
    opcEnd  = {4'd0, !held};
    addrEnd = opcEnd + {3'd0, cmd.addrLen};
    dumEnd  = addrEnd + {1'b0, cmd.dummyLen};
    total   = dumEnd + {2'd0, cmd.dataLen};
    tick    = (divCnt == DIV_W'(HALF_DIV - 1));
    lastBit = (bitCnt == 3'd7);
    stb      = '0;
    stb.load = (state == S_LOAD);
    stb.fall = (state == S_SHIFT) && tick && sckReg;
    stb.rise = (state == S_SHIFT) && tick && !sckReg;
    if (byteIdx < opcEnd) begin
      stb.kind = K_OPC;
    end else if (byteIdx < addrEnd) begin
      stb.kind = K_ADDR;
      stb.lane = byteIdx[1:0] - opcEnd[1:0];
    end else if (byteIdx < dumEnd) begin
      stb.kind = K_DUMMY;
    end else begin
      stb.kind = K_DATA;
      stb.lane = byteIdx[1:0] - dumEnd[1:0];
    end
    stb.store = stb.rise && lastBit && (stb.kind == K_DATA) && !cmd.isWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      divCnt   <= '0;
      bitCnt   <= '0;
      byteIdx  <= '0;
      sckReg   <= 1'b1;
      csActive <= 1'b0;
      held     <= 1'b0;
      csSel    <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          csActive <= 1'b1;
          if (!held) csSel <= cmd.csIdx;
          byteIdx  <= '0;
          state    <= (total == 5'd0) ? S_END : S_LOAD;
        end
        S_LOAD: begin
          divCnt <= '0;
          bitCnt <= '0;
          state  <= S_SHIFT;
        end
        S_SHIFT: begin
          if (tick) begin
            divCnt <= '0;
            if (sckReg) begin
              sckReg <= 1'b0;
            end else begin
              sckReg <= 1'b1;
              bitCnt <= bitCnt + 3'd1;
              if (lastBit) begin
                if ((byteIdx + 5'd1) < total) begin
                  byteIdx <= byteIdx + 5'd1;
                  state   <= S_LOAD;
                end else begin
                  state <= S_END;
                end
              end
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        default: begin
          csActive <= cmd.keep;
          held     <= cmd.keep;
          state    <= S_IDLE;
        end
      endcase
    end
  end

  assign busy = (state != S_IDLE);
  assign sclk = sckReg;

  for (genvar i = 0; i < CS_COUNT; i++) begin : g_cs
    assign csN[i] = !(csActive && (csSel == 3'(i)));
  end

  // R7: no clock edges without a selected device
  a_r7_sck_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |-> sckReg);
  // R9: a held transaction keeps its select asserted
  a_r9_held_keeps_cs: assert property (@(posedge clk) disable iff (!rstN)
    held |-> csActive);
  // R8: shifting only happens inside a selected access
  a_r8_shift_selected: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SHIFT) |-> (csActive && busy));
endmodule

// File: rtl/flash_seq_dp.sv
`timescale 1ns/1ps
module flash_seq_dp
  import flash_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  regSel,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        busy,
  input  seqStrobe_t  stb,
  input  logic        miso,
  output logic        mosi,
  output logic        start,
  output cmdFields_t  cmd
);
  logic [31:0] cmdReg, addrReg, dataReg;
  logic        errFlag, pending, cmdWrite, accept;
  logic [7:0]  txShift, rxShift, txByte, rxNext;
  logic [1:0]  addrShift;

  always_comb begin
    pending      = busy || start;
    cmdWrite     = regWrEn && (regSel == SEL_CMD);
    accept       = cmdWrite && !pending;
    cmd.csIdx    = cmdReg[26:24];
    cmd.keep     = cmdReg[15];
    cmd.isWrite  = cmdReg[8];
    cmd.addrLen  = (cmdReg[22:20] > 3'd3) ? 2'd3 : cmdReg[21:20];
    cmd.dummyLen = cmdReg[19:16];
    cmd.dataLen  = (cmdReg[11:9] > 3'd4) ? 3'd4 : cmdReg[11:9];
    rxNext       = {rxShift[6:0], miso};
    addrShift    = cmd.addrLen - 2'd1 - stb.lane;
    case (stb.kind)
      K_OPC:   txByte = cmdReg[7:0];
      K_ADDR:  txByte = addrReg[{addrShift, 3'b000} +: 8];
      K_DATA:  txByte = cmd.isWrite ? dataReg[{stb.lane, 3'b000} +: 8] : 8'h00;
      default: txByte = 8'h00;
    endcase
    regRdData = '0;
    case (regSel)
      SEL_CMD:  regRdData = cmdReg;
      SEL_ADDR: regRdData = addrReg;
      SEL_DATA: regRdData = dataReg;
      default: begin
        regRdData[BIT_PEND] = pending;
        regRdData[BIT_ERR]  = errFlag;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg  <= '0;
      addrReg <= '0;
      dataReg <= '0;
      errFlag <= 1'b0;
      start   <= 1'b0;
      txShift <= '0;
      rxShift <= '0;
      mosi    <= 1'b0;
    end else begin
      start <= accept;
      if (accept) cmdReg <= regWrData;
      if (cmdWrite && pending) errFlag <= 1'b1;
      else if (regWrEn && (regSel == SEL_STAT) && regWrData[BIT_ERR]) errFlag <= 1'b0;
      if (regWrEn && (regSel == SEL_ADDR) && !pending) addrReg <= regWrData;
      if (stb.store) dataReg[{stb.lane, 3'b000} +: 8] <= rxNext;
      else if (regWrEn && (regSel == SEL_DATA) && !pending) dataReg <= regWrData;
      if (stb.load) txShift <= txByte;
      else if (stb.fall) begin
        mosi    <= txShift[7];
        txShift <= {txShift[6:0], 1'b0};
      end
      if (stb.rise) rxShift <= rxNext;
    end
  end

  // R10: a colliding command raises the error and leaves the command intact
  a_r10_err_on_collision: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && pending) |=> (errFlag && $stable(cmdReg)));
  // R10: write-one clears the error
  a_r10_err_clear: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (regSel == SEL_STAT) && regWrData[BIT_ERR]) |=> !errFlag);
  // R11: address register locked during an access
  a_r11_addr_locked: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (regSel == SEL_ADDR) && pending) |=> $stable(addrReg));
  // R8: an accepted command raises pending
  a_r8_pending_on_accept: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (start && busy == 1'b0));
endmodule

// File: rtl/flash_seq.sv
`timescale 1ns/1ps
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int CS_COUNT = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          regSel,
  input  logic                regWrEn,
  input  logic [31:0]         regWrData,
  output logic [31:0]         regRdData,
  output logic                sclk,
  output logic [CS_COUNT-1:0] csN,
  output logic                mosi,
  input  logic                miso
);
  logic       busy, start;
  seqStrobe_t stb;
  cmdFields_t cmd;

  flash_seq_dp u_dp (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .busy(busy), .stb(stb),
    .miso(miso), .mosi(mosi), .start(start), .cmd(cmd)
  );

  flash_seq_ctrl #(.HALF_DIV(HALF_DIV), .CS_COUNT(CS_COUNT)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cmd(cmd), .busy(busy),
    .stb(stb), .sclk(sclk), .csN(csN)
  );

  // R7: never more than one device selected
  a_r7_single_cs: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));
endmodule

// File: tb/flash_seq_test.sv
`timescale 1ns/1ps
module flash_seq_test;
  localparam int CSN = 8;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] regSel = '0;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic sclk, mosi;
  logic miso = 1'b0;
  logic [CSN-1:0] csN;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  flash_seq #(.HALF_DIV(2), .CS_COUNT(CSN)) uut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .sclk(sclk), .csN(csN),
    .mosi(mosi), .miso(miso)
  );

  // flash model: captures the wire, answers on falling edges
  logic [7:0] cap [0:63];
  int capCnt = 0;
  int bitN = 0;
  int csRise = 0;
  int monFail = 0;
  logic [7:0] shiftIn = '0;
  logic [CSN-1:0] lastCs = '1;
  bit csIdlePrev = 1'b1;

  function automatic logic [7:0] respByte(input int k);
    return 8'hA5 ^ 8'(k * 29);
  endfunction

  always @(posedge sclk) if (csN != '1) begin
    shiftIn = {shiftIn[6:0], mosi};
    bitN++;
    if (bitN == 8) begin
      if (capCnt < 64) cap[capCnt] = shiftIn;
      capCnt++;
      bitN = 0;
    end
  end

  always @(negedge sclk) if (csN != '1) begin
    logic [7:0] r;
    r = respByte(capCnt);
    miso = r[3'd7 - 3'(bitN)];
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (csN == '1 && !csIdlePrev) csRise++;
      if ($countones(~csN) > 1) monFail++;
      if (csN == '1 && sclk !== 1'b1) monFail++;
      if (csN != '1) lastCs = csN;
    end
    csIdlePrev = (csN == '1);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    regSel = sel; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    regSel = sel;
    #1 d = regRdData;
  endtask

  task automatic waitDone();
    logic [31:0] s;
    int n = 0;
    do begin
      rd(2'd3, s);
      n++;
    end while (s[22] && n < 20000);
    chk(n < 20000, "R8 access completes", s, 32'h0);
  endtask

  task automatic clearCap();
    capCnt = 0; bitN = 0; csRise = 0;
  endtask

  function automatic logic [31:0] mkCmd(input logic [7:0] opc, input bit wdir,
      input int dlen, input bit keep, input int dum, input int alen, input int cs);
    return {5'd0, 3'(cs), 1'b0, 3'(alen), 4'(dum), keep, 3'd0, 3'(dlen), wdir, opc};
  endfunction

  task automatic t_reset();
    logic [31:0] s;
    chk(csN == '1, "R1 csN idle", 32'(csN), 32'hFF);
    chk(sclk == 1'b1, "R1 sclk high", 32'(sclk), 1);
    chk(mosi == 1'b0, "R1 mosi low", 32'(mosi), 0);
    rd(2'd3, s);
    chk(s == 32'h0, "R1 status zero", s, 0);
  endtask

  task automatic t_read_id();
    logic [31:0] s;
    wr(2'd2, 32'hAA00_0000);
    clearCap();
    wr(2'd0, mkCmd(8'h9F, 0, 3, 0, 0, 0, 2));
    rd(2'd3, s);
    chk(s[22] == 1'b1, "R8 pending after write", s, 32'h0040_0000);
    waitDone();
    chk(capCnt == 4, "R2 byte count", capCnt, 4);
    chk(cap[0] == 8'h9F, "R2 opcode", cap[0], 8'h9F);
    chk(cap[1] == 0 && cap[2] == 0 && cap[3] == 0, "R6 mosi low in read",
        {8'h0, cap[1], cap[2], cap[3]}, 0);
    chk(lastCs == ~(8'h01 << 2), "R2 chip select index", 32'(lastCs), 32'(~(8'h01 << 2)));
    rd(2'd2, s);
    chk(s == {8'hAA, respByte(3), respByte(2), respByte(1)}, "R6 R7 read data lanes",
        s, {8'hAA, respByte(3), respByte(2), respByte(1)});
    chk(csN == '1 && csRise == 1, "R8 release at end", 32'(csN), 32'hFF);
  endtask

  task automatic t_write();
    logic [7:0] expB [8] = '{8'h02, 8'h12, 8'h34, 8'h56, 8'h00, 8'h00, 8'hEF, 8'hBE};
    wr(2'd1, 32'hFF12_3456);
    wr(2'd2, 32'h1122_BEEF);
    clearCap();
    wr(2'd0, mkCmd(8'h02, 1, 2, 0, 2, 3, 0));
    waitDone();
    chk(capCnt == 8, "R3 R4 R5 byte count", capCnt, 8);
    for (int i = 0; i < 8; i++)
      chk(cap[i] == expB[i], "R3 R4 R5 write byte order", cap[i], expB[i]);
  endtask

  task automatic t_clamp();
    logic [7:0] expB [8] = '{8'h0B, 8'h12, 8'h34, 8'h56, 8'hEF, 8'hBE, 8'h22, 8'h11};
    clearCap();
    wr(2'd0, mkCmd(8'h0B, 1, 6, 0, 0, 7, 0));
    waitDone();
    chk(capCnt == 8, "R3 R5 clamped count", capCnt, 8);
    for (int i = 0; i < 8; i++)
      chk(cap[i] == expB[i], "R3 R5 clamped byte", cap[i], expB[i]);
    clearCap();
    wr(2'd0, mkCmd(8'h20, 1, 0, 0, 0, 2, 0));
    waitDone();
    chk(capCnt == 3 && cap[1] == 8'h34 && cap[2] == 8'h56, "R3 two-byte address",
        {8'(capCnt), cap[0], cap[1], cap[2]}, {8'd3, 8'h20, 8'h34, 8'h56});
  endtask

  task automatic t_dummy15();
    int nz = 0;
    clearCap();
    wr(2'd0, mkCmd(8'h5A, 0, 0, 0, 15, 0, 1));
    waitDone();
    for (int i = 1; i < 16; i++) if (cap[i] != 8'h00) nz++;
    chk(capCnt == 16 && cap[0] == 8'h5A && nz == 0, "R4 fifteen dummy bytes",
        {16'(capCnt), 8'(nz), cap[0]}, {16'd16, 8'd0, 8'h5A});
  endtask

  task automatic t_keep();
    logic [31:0] s;
    clearCap();
    wr(2'd0, mkCmd(8'h03, 0, 0, 1, 0, 3, 5));
    waitDone();
    chk(csN == ~(8'h01 << 5), "R9 held after first", 32'(csN), 32'(~(8'h01 << 5)));
    wr(2'd0, mkCmd(8'hEE, 0, 4, 1, 0, 0, 1));
    waitDone();
    chk(csN == ~(8'h01 << 5), "R9 held line reused", 32'(csN), 32'(~(8'h01 << 5)));
    chk(capCnt == 8 && cap[0] == 8'h03 && cap[4] == 8'h00, "R9 no second opcode",
        {16'(capCnt), cap[0], cap[4]}, {16'd8, 8'h03, 8'h00});
    rd(2'd2, s);
    chk(s == {respByte(7), respByte(6), respByte(5), respByte(4)}, "R9 continued read",
        s, {respByte(7), respByte(6), respByte(5), respByte(4)});
    wr(2'd0, mkCmd(8'h77, 0, 0, 0, 0, 0, 0));
    waitDone();
    chk(csN == '1 && capCnt == 8 && csRise == 1, "R9 empty release",
        {16'(capCnt), 8'(csRise), csN}, {16'd8, 8'd1, 8'hFF});
  endtask

  task automatic t_busy();
    logic [31:0] s;
    logic [31:0] first;
    first = mkCmd(8'h06, 1, 4, 0, 0, 0, 0);
    wr(2'd2, 32'h0102_0304);
    clearCap();
    wr(2'd0, first);
    wr(2'd2, 32'hDEAD_BEEF);
    wr(2'd1, 32'h00AB_CDEF);
    wr(2'd0, mkCmd(8'hC7, 0, 0, 0, 0, 0, 0));
    rd(2'd3, s);
    chk(s[29] && s[22], "R10 error while pending", s, 32'h2040_0000);
    waitDone();
    chk(capCnt == 5 && cap[0] == 8'h06 && cap[1] == 8'h04 && cap[4] == 8'h01,
        "R10 R11 wire bytes", {8'(capCnt), cap[0], cap[1], cap[4]}, {8'd5, 8'h06, 8'h04, 8'h01});
    rd(2'd2, s);
    chk(s == 32'h0102_0304, "R11 data write ignored", s, 32'h0102_0304);
    rd(2'd1, s);
    chk(s == 32'hFF12_3456, "R11 address write ignored", s, 32'hFF12_3456);
    rd(2'd0, s);
    chk(s == first, "R10 command discarded", s, first);
    rd(2'd3, s);
    chk(s == 32'h2000_0000, "R10 error sticky", s, 32'h2000_0000);
    wr(2'd3, 32'h2000_0000);
    rd(2'd3, s);
    chk(s == 32'h0, "R10 error cleared", s, 0);
  endtask

  initial begin
    #155_000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_read_id();
    t_write();
    t_clamp();
    t_dummy15();
    t_keep();
    t_busy();
    chk(monFail == 0, "R7 bus idle and single select", monFail, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule